// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Controller

This controller sits on the host side of a two-channel, 12-bit, simultaneous-sampling ADC that has a serial output. It drives an active-low conversion strobe and a serial clock, both derived from the system clock. It shifts in one or two serial data lanes and hands both 12-bit results to the surrounding logic as a pair of parallel words, flagged by a one-cycle valid pulse.

Each frame starts when the strobe is pulled low. A configurable number of idle system clocks then covers the converter's busy time. After that, the serial clock runs for a length that depends on the output mode:

- **Two-lane mode:** 16 pulses. Each lane carries one channel.
- **One-lane mode:** 28 pulses. Lane A carries channel 1 followed by channel 2.

Three leading zero bits are dropped, and the remaining bits arrive most significant first. In one-shot operation the strobe is held low through the final clock edge. In continuous operation it rises part-way through the frame, so the converter keeps running, and holding start repeats frames back to back.

The sequencer has four states:

- **ST_IDLE:** strobe high, serial clock parked low.
- **ST_CONVERT:** strobe low, counting idle clocks.
- **ST_SHIFT:** serial clock toggling while data is sampled.
- **ST_GAP:** one cycle with the strobe high and the valid pulse out.

The transitions are:

- **launch:** ST_IDLE to ST_CONVERT on a start request.
- **convert_done:** ST_CONVERT to ST_SHIFT when the idle count is reached.
- **frame_end:** ST_SHIFT to ST_GAP on the last falling edge.
- **relaunch:** ST_GAP to ST_CONVERT when continuous and start is high.
- **stop:** ST_GAP to ST_IDLE otherwise.

Top module: `adcs_capture_ctrl`

## Requirements
- R1: While rst_n is low, and at once when it falls (also in the middle of a frame), cnv_o is high, sclk_o low, valid_o low, and ch1_o and ch2_o are zero.
- R2: When a frame is launched, cnv_o falls. The first rising edge of sclk_o then comes after exactly conv_idle_i + 1 + h system clocks with sclk_o low, where h = div_half_i, or 1 when div_half_i is 0.
- R3: Each high phase of sclk_o lasts h system clocks, and sclk_o stays low whenever no frame is shifting.
- R4: With single_i = 0, a frame has exactly 16 sclk_o rising edges. Lane values are sampled in the system clock cycle in which sclk_o goes high. The samples taken at rising edges 2 to 4 are discarded. Rising edges 5 to 16 give bits 11 down to 0, lane A into ch1_o and lane B into ch2_o.
- R5: With single_i = 1, a frame has exactly 28 sclk_o rising edges. Lane A samples at rising edges 5 to 16 give ch1_o bits 11 down to 0, and rising edges 17 to 28 give ch2_o bits 11 down to 0. Lane B has no effect.
- R6: With cont_i = 0, cnv_o stays low through the last falling edge and rises in the cycle that edge is made. A frame is launched only by a low-to-high change of start_i, so holding start_i high yields one frame.
- R7: With cont_i = 1, cnv_o rises with the 15th falling edge of sclk_o. If start_i is high in the valid_o cycle, cnv_o falls in the next cycle and a new frame follows. If start_i is low then, no new frame starts.
- R8: valid_o is high for exactly one cycle per frame, in the cycle after the last falling edge of sclk_o, with sclk_o low.
- R9: ch1_o and ch2_o change only in a cycle where valid_o is high, and hold their values between pulses.
- R10: single_i, cont_i, div_half_i and conv_idle_i are taken when cnv_o falls. Changes during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request (edge in one-shot, level in continuous) |
| single_i | input | 1 | 1: one-lane mode (28 pulses), 0: two-lane mode (16 pulses) |
| cont_i | input | 1 | 1: continuous conversion, 0: one-shot |
| div_half_i | input | DIV_W | Serial clock half period in system clocks (0 acts as 1) |
| conv_idle_i | input | IDLE_W | Extra idle clocks after strobe fall, before clocking |
| cnv_o | output | 1 | Active-low conversion strobe |
| sclk_o | output | 1 | Serial clock to the converter |
| sdo_a_i | input | 1 | Serial data lane A |
| sdo_b_i | input | 1 | Serial data lane B |
| ch1_o | output | DATA_W | Channel 1 result |
| ch2_o | output | DATA_W | Channel 2 result |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
Three things fall on the same clock edge: the capture of a finished frame, the valid pulse it raises, and the sequencer's decision in ST_GAP whether to relaunch. A continuous frame whose valid cycle sees start_i dropped exercises all three at once. The bench drops start_i at exactly the sample where valid_o appears. It then judges that the results are intact, that valid_o was a single cycle, and that cnv_o never falls again. With start_i kept high instead, it checks that cnv_o falls in the very next cycle and that the second frame's words are correct.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_SHIFT,
        ST_GAP
    } adcs_state_e;

endpackage

// File: rtl/adcs_sclk_gen.sv
module adcs_sclk_gen #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick,
    output logic [CNT_W-1:0] rises
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;
    logic             hit;

    // a half period of zero behaves as one
    assign last      = (half == '0) ? '0 : half - 1'b1;
    assign hit       = en && (cnt_q == last);
    assign rise_tick = hit && !sclk;
    assign fall_tick = hit && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
            rises <= '0;
        end else if (!en) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
            rises <= '0;
        end else if (hit) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
            if (!sclk) begin
                rises <= rises + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adcs_deser.sv
module adcs_deser #(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 3,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [CNT_W-1:0]  idx,
    input  logic              single,
    input  logic              lane_a,
    input  logic              lane_b,
    output logic [DATA_W-1:0] word1,
    output logic [DATA_W-1:0] word2
);

    // rise index windows holding the first and second result words
    localparam logic [CNT_W-1:0] W1_LO = CNT_W'(LEAD_ZEROS + 2);
    localparam logic [CNT_W-1:0] W1_HI = CNT_W'(LEAD_ZEROS + 1 + DATA_W);
    localparam logic [CNT_W-1:0] W2_LO = CNT_W'(LEAD_ZEROS + 2 + DATA_W);
    localparam logic [CNT_W-1:0] W2_HI = CNT_W'(LEAD_ZEROS + 1 + 2 * DATA_W);

    logic              in_first;
    logic              in_second;
    logic [1:0]        shift_en;
    logic [1:0]        bit_in;
    logic [DATA_W-1:0] word_q [2];

    assign in_first  = (idx >= W1_LO) && (idx <= W1_HI);
    assign in_second = (idx >= W2_LO) && (idx <= W2_HI);

    assign shift_en[0] = sample && in_first;
    assign bit_in[0]   = lane_a;
    assign shift_en[1] = sample && (single ? in_second : in_first);
    assign bit_in[1]   = single ? lane_a : lane_b;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[c] <= '0;
            end else if (shift_en[c]) begin
                word_q[c] <= {word_q[c][DATA_W-2:0], bit_in[c]};
            end
        end
    end

    assign word1 = word_q[0];
    assign word2 = word_q[1];

endmodule

// File: rtl/adcs_capture_ctrl.sv
module adcs_capture_ctrl
    import adcs_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 3,
    parameter int DIV_W      = 8,
    parameter int IDLE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              single_i,
    input  logic              cont_i,
    input  logic [DIV_W-1:0]  div_half_i,
    input  logic [IDLE_W-1:0] conv_idle_i,
    output logic              cnv_o,
    output logic              sclk_o,
    input  logic              sdo_a_i,
    input  logic              sdo_b_i,
    output logic [DATA_W-1:0] ch1_o,
    output logic [DATA_W-1:0] ch2_o,
    output logic              valid_o
);

    localparam int DUAL_LEN_I   = LEAD_ZEROS + DATA_W + 1;
    localparam int SINGLE_LEN_I = LEAD_ZEROS + 2 * DATA_W + 1;
    localparam int CNT_W        = $clog2(SINGLE_LEN_I + 1);

    localparam logic [CNT_W-1:0] DUAL_LEN   = CNT_W'(DUAL_LEN_I);
    localparam logic [CNT_W-1:0] SINGLE_LEN = CNT_W'(SINGLE_LEN_I);
    // falling edge that ends the last data bit of a two-lane frame
    localparam logic [CNT_W-1:0] RAISE_AT   = CNT_W'(LEAD_ZEROS + DATA_W);

    adcs_state_e       state_q;
    adcs_state_e       state_d;
    logic              start_d_q;
    logic              single_q;
    logic              cont_q;
    logic [DIV_W-1:0]  half_q;
    logic [IDLE_W-1:0] idle_q;
    logic [IDLE_W-1:0] idle_cnt_q;

    logic              shifting;
    logic              rise_tick;
    logic              fall_tick;
    logic [CNT_W-1:0]  rises;
    logic [CNT_W-1:0]  frame_len;
    logic [DATA_W-1:0] word1;
    logic [DATA_W-1:0] word2;
    logic              launch;
    logic              frame_end;

    assign shifting  = (state_q == ST_SHIFT);
    assign frame_len = single_q ? SINGLE_LEN : DUAL_LEN;
    assign frame_end = fall_tick && (rises == frame_len);

    // one-shot needs a fresh edge on start, continuous follows its level
    assign launch = ((state_q == ST_IDLE) && start_i && (cont_i || !start_d_q)) ||
                    ((state_q == ST_GAP)  && start_i && cont_q);

    adcs_sclk_gen #(
        .DIV_W (DIV_W),
        .CNT_W (CNT_W)
    ) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (shifting),
        .half      (half_q),
        .sclk      (sclk_o),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .rises     (rises)
    );

    adcs_deser #(
        .DATA_W     (DATA_W),
        .LEAD_ZEROS (LEAD_ZEROS),
        .CNT_W      (CNT_W)
    ) u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (rise_tick),
        .idx    (rises + 1'b1),
        .single (single_q),
        .lane_a (sdo_a_i),
        .lane_b (sdo_b_i),
        .word1  (word1),
        .word2  (word2)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch) state_d = ST_CONVERT;
            ST_CONVERT: if (idle_cnt_q == idle_q) state_d = ST_SHIFT;
            ST_SHIFT:   if (frame_end) state_d = ST_GAP;
            ST_GAP:     state_d = launch ? ST_CONVERT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            start_d_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            start_d_q <= start_i;
        end
    end

    // frame configuration, taken as the strobe falls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            single_q   <= 1'b0;
            cont_q     <= 1'b0;
            half_q     <= '0;
            idle_q     <= '0;
            idle_cnt_q <= '0;
        end else if ((state_d == ST_CONVERT) && (state_q != ST_CONVERT)) begin
            single_q   <= single_i;
            cont_q     <= cont_i;
            half_q     <= div_half_i;
            idle_q     <= conv_idle_i;
            idle_cnt_q <= '0;
        end else if (state_q == ST_CONVERT) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_o   <= 1'b1;
            valid_o <= 1'b0;
            ch1_o   <= '0;
            ch2_o   <= '0;
        end else begin
            unique case (state_d)
                ST_IDLE, ST_GAP: cnv_o <= 1'b1;
                ST_CONVERT:      cnv_o <= 1'b0;
                ST_SHIFT: begin
                    if (cont_q && fall_tick && (rises == RAISE_AT)) begin
                        cnv_o <= 1'b1;
                    end
                end
                default:         cnv_o <= 1'b1;
            endcase
            valid_o <= shifting && (state_d == ST_GAP);
            if (shifting && (state_d == ST_GAP)) begin
                ch1_o <= word1;
                ch2_o <= word2;
            end
        end
    end

endmodule

// File: rtl/adcs_capture_chk.sv
module adcs_capture_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnv_o,
    input logic              sclk_o,
    input logic              valid_o,
    input logic              in_shift,
    input logic [DATA_W-1:0] ch1_o,
    input logic [DATA_W-1:0] ch2_o
);

    // R3
    sclk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_shift |-> !sclk_o);

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8
    valid_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!sclk_o && !in_shift));

    // R6
    cnv_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> !sclk_o);

    // R2
    cnv_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_o) |=> !sclk_o);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ch1_o) || !$stable(ch2_o)) |-> valid_o);

endmodule

bind adcs_capture_ctrl adcs_capture_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv_o    (cnv_o),
    .sclk_o   (sclk_o),
    .valid_o  (valid_o),
    .in_shift (shifting),
    .ch1_o    (ch1_o),
    .ch2_o    (ch2_o)
);

// File: tb/tb_adcs_capture_ctrl.sv
module tb_adcs_capture_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        single_i = 1'b0;
    logic        cont_i = 1'b0;
    logic [7:0]  div_half_i = 8'd1;
    logic [7:0]  conv_idle_i = 8'd0;
    logic        cnv_o;
    logic        sclk_o;
    logic        sdo_a_i = 1'b0;
    logic        sdo_b_i = 1'b0;
    logic [11:0] ch1_o;
    logic [11:0] ch2_o;
    logic        valid_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    adcs_capture_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .single_i    (single_i),
        .cont_i      (cont_i),
        .div_half_i  (div_half_i),
        .conv_idle_i (conv_idle_i),
        .cnv_o       (cnv_o),
        .sclk_o      (sclk_o),
        .sdo_a_i     (sdo_a_i),
        .sdo_b_i     (sdo_b_i),
        .ch1_o       (ch1_o),
        .ch2_o       (ch2_o),
        .valid_o     (valid_o)
    );

    // converter model: words it will send next
    logic [11:0] cur_w1 = '0;
    logic [11:0] cur_w2 = '0;

    always begin
        int n;
        logic sing;
        @(negedge cnv_o);
        sing = single_i;
        n = sing ? 28 : 16;
        sdo_a_i = 1'b0;
        sdo_b_i = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(posedge sclk_o);
            #1;
            if (sing) begin
                if (k >= 4 && k <= 15)       sdo_a_i = cur_w1[15-k];
                else if (k >= 16 && k <= 27) sdo_a_i = cur_w2[27-k];
                else                         sdo_a_i = 1'b0;
                sdo_b_i = k[0];
            end else begin
                if (k >= 4 && k <= 15) begin
                    sdo_a_i = cur_w1[15-k];
                    sdo_b_i = cur_w2[15-k];
                end else begin
                    sdo_a_i = 1'b0;
                    sdo_b_i = 1'b0;
                end
            end
        end
    end

    // port monitor, sampled away from the active edge
    int   m_rises = 0, m_lead = 0, m_hrun = 0, m_high = 0;
    int   m_rec_rises = 0, m_vcount = 0, m_pulse_err = 0;
    logic m_rec_sclk = 1'b0;
    logic p_cnv = 1'b1, p_sclk = 1'b0, p_valid = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_rises = 0;
            m_lead = 0;
            p_cnv = 1'b1;
            p_sclk = 1'b0;
            p_valid = 1'b0;
        end else begin
            if (p_cnv && !cnv_o) begin
                m_rises = 0;
                m_lead = 0;
            end
            if (!cnv_o && m_rises == 0 && !sclk_o) m_lead++;
            if (!p_sclk && sclk_o) begin
                m_rises++;
                m_hrun = 1;
            end else if (sclk_o) begin
                m_hrun++;
            end
            if (p_sclk && !sclk_o) m_high = m_hrun;
            if (!p_cnv && cnv_o) begin
                m_rec_rises = m_rises;
                m_rec_sclk = sclk_o;
            end
            if (valid_o) m_vcount++;
            if (valid_o && p_valid) m_pulse_err++;
            p_cnv = cnv_o;
            p_sclk = sclk_o;
            p_valid = valid_o;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!valid_o);
        #1;
    endtask

    task automatic check_frame(input logic sing, input logic cont, input int h,
                               input int idle, input logic [11:0] w1,
                               input logic [11:0] w2);
        int n;
        n = sing ? 28 : 16;
        if (sing) begin
            chk("R5 ch1", int'(ch1_o), int'(w1));
            chk("R5 ch2", int'(ch2_o), int'(w2));
            chk("R5 pulses", m_rises, n);
        end else begin
            chk("R4 ch1", int'(ch1_o), int'(w1));
            chk("R4 ch2", int'(ch2_o), int'(w2));
            chk("R4 pulses", m_rises, n);
        end
        chk("R2 lead", m_lead, idle + 1 + h);
        chk("R3 high phase", m_high, h);
        if (cont) chk("R7 strobe rise edge", m_rec_rises, 15);
        else      chk("R6 strobe rise edge", m_rec_rises, n);
        chk("R8 sclk low at valid", int'(sclk_o), 0);
    endtask

    // {single, cont, div_half, conv_idle, word1, word2}
    localparam logic [41:0] VEC [6] = '{
        {1'b0, 1'b0, 8'd1, 8'd0, 12'hA5C, 12'h3E1},
        {1'b0, 1'b0, 8'd3, 8'd5, 12'h800, 12'h001},
        {1'b1, 1'b0, 8'd2, 8'd2, 12'hF0F, 12'h1B6},
        {1'b1, 1'b0, 8'd0, 8'd0, 12'hFFF, 12'h000},
        {1'b0, 1'b1, 8'd2, 8'd1, 12'h123, 12'hFED},
        {1'b1, 1'b1, 8'd1, 8'd3, 12'h7A5, 12'hC3C}
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int vbase;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 cnv", int'(cnv_o), 1);
        chk("R1 sclk", int'(sclk_o), 0);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 ch1", int'(ch1_o), 0);
        chk("R1 ch2", int'(ch2_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            logic        vs, vc;
            logic [11:0] w1, w2;
            int          h, idl;
            vs  = VEC[i][41];
            vc  = VEC[i][40];
            h   = (VEC[i][39:32] == 8'd0) ? 1 : int'(VEC[i][39:32]);
            idl = int'(VEC[i][31:24]);
            w1  = VEC[i][23:12];
            w2  = VEC[i][11:0];
            @(negedge clk);
            single_i = vs;
            cont_i = vc;
            div_half_i = VEC[i][39:32];
            conv_idle_i = VEC[i][31:24];
            cur_w1 = w1;
            cur_w2 = w2;
            start_i = 1'b1;
            if (!vc) begin
                @(negedge clk);
                start_i = 1'b0;
            end
            wait_valid();
            check_frame(vs, vc, h, idl, w1, w2);
            if (vc) begin
                // relaunch while start held: strobe falls next cycle (R7)
                cur_w1 = ~w1;
                cur_w2 = w2 ^ 12'h555;
                @(negedge clk);
                chk("R7 relaunch", int'(cnv_o), 0);
                wait_valid();
                check_frame(vs, vc, h, idl, ~w1, w2 ^ 12'h555);
                // drop start in the valid cycle: no further frame (R7)
                start_i = 1'b0;
                vbase = m_vcount;
                repeat (80) begin
                    @(negedge clk);
                    if (!cnv_o) begin
                        chk("R7 stop", 0, 1);
                        break;
                    end
                end
                chk("R7 no extra valid", m_vcount, vbase);
            end
            repeat (4) @(negedge clk);
        end

        // R6 one-shot with start held high yields one frame
        @(negedge clk);
        single_i = 1'b0;
        cont_i = 1'b0;
        div_half_i = 8'd1;
        conv_idle_i = 8'd0;
        cur_w1 = 12'h05A;
        cur_w2 = 12'hA50;
        vbase = m_vcount;
        start_i = 1'b1;
        repeat (200) @(negedge clk);
        chk("R6 held start frames", m_vcount - vbase, 1);
        chk("R6 strobe idle high", int'(cnv_o), 1);
        start_i = 1'b0;
        repeat (3) @(negedge clk);

        // R10 config changed mid-frame is ignored
        div_half_i = 8'd2;
        cur_w1 = 12'h9C3;
        cur_w2 = 12'h36C;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        single_i = 1'b1;
        div_half_i = 8'd5;
        conv_idle_i = 8'd7;
        wait_valid();
        chk("R10 ch1", int'(ch1_o), 12'h9C3);
        chk("R10 ch2", int'(ch2_o), 12'h36C);
        chk("R10 pulses", m_rises, 16);
        chk("R10 high phase", m_high, 2);
        chk("R8 pulse width", m_pulse_err, 0);

        // R9 results hold between pulses
        repeat (20) @(negedge clk);
        chk("R9 ch1 hold", int'(ch1_o), 12'h9C3);
        chk("R9 ch2 hold", int'(ch2_o), 12'h36C);

        // R1 reset in the middle of a frame
        single_i = 1'b0;
        div_half_i = 8'd1;
        conv_idle_i = 8'd0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid cnv", int'(cnv_o), 1);
        chk("R1 mid sclk", int'(sclk_o), 0);
        chk("R1 mid ch1", int'(ch1_o), 0);
        chk("R1 mid valid", int'(valid_o), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule